// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked request/acknowledge port and an 8K x 8 asynchronous static RAM with a shared data bus. A transaction is started by a one-cycle request that carries a direction, a 13-bit address and, for a write, a data byte. The controller then produces the RAM's pin sequence. There is an active-low enable, an active-high enable, an active-low write strobe, an active-low read strobe, a registered address, a registered outgoing data byte, and a drive-enable for the system side of the data bus. A one-cycle acknowledge closes the transaction. For a read, the acknowledge also carries the byte that was sampled.

Each phase lasts a whole number of clock cycles set by parameters: address setup, write pulse, read access and bus turnaround. A check at elaboration compares these counts, at the given clock period, against the minimum timings of the 70 ns or 100 ns grade. A mode parameter chooses which pin ends a write: the write strobe, the active-low enable or the active-high enable. The other two pins are made active one cycle earlier and released one cycle later. After every transaction the RAM is deselected and the bus is left alone for the turnaround count. This lets the RAM's output drivers switch off before the controller drives the bus again. Only one transaction is in flight at a time.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and after it is released with no request, ram_sel_n=1, ram_sel=0, ram_wr_n=1, ram_rd_n=1, ram_dq_oe=0 and ack=0.
- R2: A read (we=0) deselects the RAM for SU_CYC cycles with the new address presented. It then holds ram_sel_n=0, ram_sel=1, ram_wr_n=1 and ram_rd_n=0 for ACC_CYC cycles, and samples ram_dq_in on the clock edge that ends them. The sampled byte appears on rdata by the ack cycle.
- R3: A write (we=1) drives ram_dq_out with the request's byte and ram_dq_oe=1 from the first cycle after acceptance until one cycle after the write ends. All three strobes are active together for WP_CYC cycles, and ram_rd_n stays 1.
- R4: END_MODE picks the pin that ends a write: 0 = ram_wr_n rises, 1 = ram_sel_n rises, 2 = ram_sel falls. In the cycle before and the cycle after the common active window, only that pin is inactive and the other two are active.
- R5: Every transaction ends with TURN_CYC cycles in which the RAM is deselected and ram_dq_oe=0. ack is high in the following cycle. That is SU_CYC+ACC_CYC+TURN_CYC cycles after the accepting edge for a read, and SU_CYC+WP_CYC+1+TURN_CYC cycles for a write. A request in the ack cycle is accepted.
- R6: ram_dq_oe is never 1 while the RAM is selected with ram_wr_n=1 and ram_rd_n=0. It is also never 1 within TURN_CYC cycles after that condition ends.
- R7: ram_addr is stable while a write is active, and ram_dq_out is stable while ram_dq_oe stays 1.
- R8: A request seen while a transaction is in progress is ignored: no extra ack, and no change to the RAM contents.
- R9: ack is high for exactly one cycle per transaction, and rdata keeps the last read byte until the next read completes.
- R10: ram_wr_n and ram_rd_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle transaction request |
| we | input | 1 | 1 = write, 0 = read (qualified by req) |
| addr | input | ADDR_W | Transaction address |
| wdata | input | DATA_W | Write byte |
| ack | output | 1 | One-cycle transaction completion |
| rdata | output | DATA_W | Last byte read |
| ram_addr | output | ADDR_W | Address pins of the RAM |
| ram_sel_n | output | 1 | Active-low chip enable |
| ram_sel | output | 1 | Active-high chip enable |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_dq_out | output | DATA_W | Byte driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the shared data bus |
| ram_dq_in | input | DATA_W | Byte seen on the shared data bus |

## Verification
The assertions assume that `req` is only asserted while no transaction is open or in the ack cycle. A request at any other time may occur, but it must not be expected to take effect. They also assume the parameter counts fit the timing grade, since the turnaround and pulse-length checks count cycles rather than nanoseconds. The stimulus issues each request as a one-cycle pulse from a task that waits for `ack` before issuing the next one. One deliberate exception is a request placed in the middle of a read to exercise R8. Three controllers, one per write-ending mode, receive identical requests, and each one drives its own RAM model. Each model measures pulse widths, setup and turnaround in nanoseconds, and it presents garbage on the bus until its access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  // pin levels exactly as they appear at the RAM
  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic drive;
  } pins_t;

  localparam pins_t PINS_QUIET = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};

  localparam int END_BY_WR    = 0;
  localparam int END_BY_SEL_N = 1;
  localparam int END_BY_SEL   = 2;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // minimum nanosecond limits per grade versus cycle counts at the clock period
  function automatic bit timing_ok(int per_ps, int grade_ns, int su, int wp, int acc, int turn);
    int t_wp;
    int t_ds;
    int t_cyc;
    int t_dis;
    bit fast;
    fast  = (grade_ns <= 70);
    t_wp  = fast ? 50 : 70;
    t_ds  = fast ? 35 : 40;
    t_cyc = fast ? 70 : 100;
    t_dis = fast ? 30 : 35;
    return (su >= 1) && (turn >= 1) && (wp >= 1) && (acc >= 1) &&
           (wp * per_ps >= t_wp * 1000) &&
           ((su + wp) * per_ps >= t_ds * 1000) &&
           (acc * per_ps >= t_cyc * 1000) &&
           ((su + wp + 1) * per_ps >= t_cyc * 1000) &&
           (turn * per_ps >= t_dis * 1000);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SU_CYC   = 1,
  parameter int WP_CYC   = 7,
  parameter int ACC_CYC  = 9,
  parameter int TURN_CYC = 4,
  parameter int CW       = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   we,
  output phase_e phase_d,
  output logic   wr_d,
  output logic   accept,
  output logic   capture,
  output logic   done
);

  phase_e        phase_q;
  logic          wr_q;
  logic          load;
  logic [CW-1:0] len;
  logic          expire;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (len),
    .expire   (expire)
  );

  always_comb begin
    phase_d = phase_q;
    wr_d    = wr_q;
    load    = 1'b0;
    len     = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          phase_d = PH_SETUP;
          wr_d    = we;
          load    = 1'b1;
          len     = CW'(SU_CYC - 1);
        end
      end
      PH_SETUP: begin
        if (expire) begin
          phase_d = PH_STROBE;
          load    = 1'b1;
          len     = wr_q ? CW'(WP_CYC - 1) : CW'(ACC_CYC - 1);
        end
      end
      PH_STROBE: begin
        if (expire) begin
          load    = 1'b1;
          if (wr_q) begin
            phase_d = PH_HOLD;
            len     = '0;
          end else begin
            phase_d = PH_RECOV;
            len     = CW'(TURN_CYC - 1);
          end
        end
      end
      PH_HOLD: begin
        if (expire) begin
          phase_d = PH_RECOV;
          load    = 1'b1;
          len     = CW'(TURN_CYC - 1);
        end
      end
      PH_RECOV: begin
        if (expire) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
    end
  end

  assign accept  = (phase_q == PH_IDLE) && req;
  assign capture = (phase_q == PH_STROBE) && !wr_q && expire;
  assign done    = (phase_q == PH_RECOV) && expire;

endmodule

// File: rtl/sram_pin_map.sv
module sram_pin_map
  import sram_ctrl_pkg::*;
#(
  parameter int END_MODE = END_BY_WR
) (
  input  phase_e phase,
  input  logic   wr,
  output pins_t  pins
);

  // pattern used just before and just after the common write window
  pins_t edge_pat;

  generate
    if (END_MODE == END_BY_SEL_N) begin : g_end_sel_n
      assign edge_pat = '{sel_n: 1'b1, sel: 1'b1, wr_n: 1'b0, rd_n: 1'b1, drive: 1'b1};
    end else if (END_MODE == END_BY_SEL) begin : g_end_sel
      assign edge_pat = '{sel_n: 1'b0, sel: 1'b0, wr_n: 1'b0, rd_n: 1'b1, drive: 1'b1};
    end else begin : g_end_wr
      assign edge_pat = '{sel_n: 1'b0, sel: 1'b1, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b1};
    end
  endgenerate

  always_comb begin
    pins = PINS_QUIET;
    unique case (phase)
      PH_SETUP, PH_HOLD: begin
        if (wr) pins = edge_pat;
      end
      PH_STROBE: begin
        pins.sel_n = 1'b0;
        pins.sel   = 1'b1;
        if (wr) begin
          pins.wr_n  = 1'b0;
          pins.drive = 1'b1;
        end else begin
          pins.rd_n  = 1'b0;
        end
      end
      default: pins = PINS_QUIET;
    endcase
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int GRADE_NS = 70,
  parameter int SU_CYC   = 1,
  parameter int WP_CYC   = 7,
  parameter int ACC_CYC  = 9,
  parameter int TURN_CYC = 4,
  parameter int END_MODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_wr_n,
  output logic              ram_rd_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int MAXC = max4(SU_CYC, WP_CYC, ACC_CYC, TURN_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam bit TIMING_FITS = timing_ok(CLK_PS, GRADE_NS, SU_CYC, WP_CYC, ACC_CYC, TURN_CYC);

  generate
    if (!TIMING_FITS) begin : g_timing_short
      $error("sram_async_ctrl: cycle counts do not meet the selected speed grade");
    end
  endgenerate

  phase_e phase_d;
  logic   wr_d;
  logic   accept;
  logic   capture;
  logic   done;
  pins_t  pins_d;
  pins_t  pins_q;

  sram_seq #(
    .SU_CYC   (SU_CYC),
    .WP_CYC   (WP_CYC),
    .ACC_CYC  (ACC_CYC),
    .TURN_CYC (TURN_CYC),
    .CW       (CW)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .phase_d (phase_d),
    .wr_d    (wr_d),
    .accept  (accept),
    .capture (capture),
    .done    (done)
  );

  sram_pin_map #(.END_MODE(END_MODE)) u_map (
    .phase (phase_d),
    .wr    (wr_d),
    .pins  (pins_d)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q  <= PINS_QUIET;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      pins_q <= pins_d;
      ack_q  <= done;
      if (accept) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (capture) rdata_q <= ram_dq_in;
    end
  end

  assign ack        = ack_q;
  assign rdata      = rdata_q;
  assign ram_addr   = addr_q;
  assign ram_sel_n  = pins_q.sel_n;
  assign ram_sel    = pins_q.sel;
  assign ram_wr_n   = pins_q.wr_n;
  assign ram_rd_n   = pins_q.rd_n;
  assign ram_dq_out = wdata_q;
  assign ram_dq_oe  = pins_q.drive;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int WP_CYC   = 7,
  parameter int TURN_CYC = 4,
  parameter int END_MODE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_sel_n,
  input logic              ram_sel,
  input logic              ram_wr_n,
  input logic              ram_rd_n,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic              ram_dq_oe
);

  localparam int GW = 16;

  logic          selected;
  logic          ram_drives;
  logic          wr_active;
  logic          end_pat;
  logic [GW-1:0] since_drive;
  logic [GW-1:0] wr_len;

  assign selected   = !ram_sel_n && ram_sel;
  assign ram_drives = selected && ram_wr_n && !ram_rd_n;
  assign wr_active  = selected && !ram_wr_n;

  generate
    if (END_MODE == 1) begin : g_pat_sel_n
      assign end_pat = ram_sel_n && ram_sel && !ram_wr_n;
    end else if (END_MODE == 2) begin : g_pat_sel
      assign end_pat = !ram_sel_n && !ram_sel && !ram_wr_n;
    end else begin : g_pat_wr
      assign end_pat = !ram_sel_n && ram_sel && ram_wr_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      since_drive <= GW'(TURN_CYC);
      wr_len      <= '0;
    end else begin
      if (ram_drives) since_drive <= '0;
      else if (since_drive < GW'(TURN_CYC)) since_drive <= since_drive + 1'b1;
      if (wr_active) begin
        if (wr_len != '1) wr_len <= wr_len + 1'b1;
      end else begin
        wr_len <= '0;
      end
    end
  end

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> !ram_drives);

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (since_drive >= GW'(TURN_CYC)));

  // R3
  write_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_active && $past(wr_active)) |-> (wr_len >= GW'(WP_CYC)));

  // R4
  write_end_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_active && $past(wr_active)) |-> end_pat);

  // R4
  write_start_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_active && !$past(wr_active)) |-> $past(end_pat));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_wr_n && $past(!ram_wr_n)) |-> $stable(ram_addr));

  // R7
  wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ram_wr_n && !ram_rd_n));

  // R5
  ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!selected && !ram_dq_oe && $past(!selected)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WP_CYC   (WP_CYC),
  .TURN_CYC (TURN_CYC),
  .END_MODE (END_MODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack        (ack),
  .ram_addr   (ram_addr),
  .ram_sel_n  (ram_sel_n),
  .ram_sel    (ram_sel),
  .ram_wr_n   (ram_wr_n),
  .ram_rd_n   (ram_rd_n),
  .ram_dq_out (ram_dq_out),
  .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_model #(
  parameter int MODE   = 0,
  parameter int PER_NS = 8,
  parameter int ACC_NS = 70,
  parameter int WP_NS  = 50,
  parameter int DS_NS  = 35,
  parameter int DIS_NS = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [12:0] addr,
  input  logic        sel_n,
  input  logic        sel,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [7:0]  dq_out,
  input  logic        dq_oe,
  output logic [7:0]  dq_in,
  output int          nchk,
  output int          nfail
);

  logic [7:0]  mem [int];
  int          since = 1000;
  int          wcnt = 0;
  int          rcnt = 0;
  int          stable = 0;
  int          stable_wr = 0;
  logic [7:0]  last_d = 8'h00;
  logic [12:0] waddr = '0;
  logic [12:0] raddr = '0;
  logic [7:0]  wdat = 8'h00;
  bit          prev_wa = 0;
  bit          prev_pat = 0;

  initial begin
    nchk  = 0;
    nfail = 0;
    dq_in = 8'hEE;
  end

  function automatic bit edge_pattern(logic s_n, logic s, logic w_n);
    if (MODE == 1) return s_n && s && !w_n;
    if (MODE == 2) return !s_n && !s && !w_n;
    return !s_n && s && w_n;
  endfunction

  always @(negedge clk) begin
    bit selected;
    bit wa;
    bit rdrv;
    bit pat;
    if (!rst) begin
      selected = !sel_n && sel;
      wa       = selected && !wr_n;
      rdrv     = selected && wr_n && !rd_n;
      pat      = edge_pattern(sel_n, sel, wr_n);
      if (!wr_n && !rd_n) begin
        nfail++; $display("FAIL R10: strobes both low got wr_n=%b rd_n=%b expected not both 0", wr_n, rd_n);
      end
      if (dq_oe && rdrv) begin
        nfail++; $display("FAIL R6: bus contention got oe=1 with RAM driving expected oe=0");
      end
      if (dq_oe && since * PER_NS < DIS_NS) begin
        nfail++; $display("FAIL R6: drive %0d ns after RAM release expected >= %0d", since * PER_NS, DIS_NS);
      end
      since = rdrv ? 0 : (since < 1000 ? since + 1 : since);
      if (dq_oe) begin
        stable = (dq_out == last_d) ? stable + 1 : 1;
        last_d = dq_out;
      end else begin
        stable = 0;
      end
      if (wa) begin
        if (!prev_wa) begin
          nchk++;
          if (!prev_pat) begin
            nfail++; $display("FAIL R4: write start pattern mode %0d got 0 expected 1", MODE);
          end
        end
        if (wcnt > 0 && addr != waddr) begin
          nfail++; $display("FAIL R7: address moved during write got %h expected %h", addr, waddr);
        end
        if (!dq_oe) begin
          nfail++; $display("FAIL R3: data not driven during write got 0 expected 1");
        end
        wcnt++;
        waddr = addr;
        wdat = dq_out;
        stable_wr = stable;
      end else if (prev_wa) begin
        nchk += 3;
        if (wcnt * PER_NS < WP_NS) begin
          nfail++; $display("FAIL R3: write pulse %0d ns expected >= %0d", wcnt * PER_NS, WP_NS);
        end
        if (stable_wr * PER_NS < DS_NS) begin
          nfail++; $display("FAIL R3: data setup %0d ns expected >= %0d", stable_wr * PER_NS, DS_NS);
        end
        if (!pat) begin
          nfail++; $display("FAIL R4: write end pattern mode %0d got sel_n=%b sel=%b wr_n=%b expected ending pin only", MODE, sel_n, sel, wr_n);
        end
        mem[int'(waddr)] = wdat;
        wcnt = 0;
      end
      if (rdrv) begin
        if (rcnt > 0 && addr != raddr) rcnt = 0;
        rcnt++;
        raddr = addr;
        if (rcnt * PER_NS >= ACC_NS) dq_in = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
        else dq_in = 8'hEE;
      end else begin
        rcnt = 0;
        dq_in = 8'hEE;
      end
      prev_wa  = wa;
      prev_pat = pat;
    end
  end

endmodule

module sram_async_ctrl_tb;

  localparam int SU = 1;
  localparam int WP = 7;
  localparam int AC = 9;
  localparam int TN = 4;
  localparam int LAT_RD = SU + AC + TN;
  localparam int LAT_WR = SU + WP + 1 + TN;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;

  logic        ack [3];
  logic [7:0]  rdata [3];
  logic [12:0] r_addr [3];
  logic        r_sel_n [3];
  logic        r_sel [3];
  logic        r_wr_n [3];
  logic        r_rd_n [3];
  logic [7:0]  r_dq_out [3];
  logic        r_dq_oe [3];
  logic [7:0]  r_dq_in [3];
  int          m_chk [3];
  int          m_fail [3];

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    bit         rd;
    logic [7:0] exp;
  } item_t;

  item_t      sb_q [$];
  logic [7:0] ref_mem [int];
  logic [7:0] last_rd = 8'h00;
  bit         prev_ack = 0;

  always #4 clk = ~clk;

  sram_async_ctrl #(.END_MODE(0)) u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack[0]), .rdata(rdata[0]), .ram_addr(r_addr[0]), .ram_sel_n(r_sel_n[0]),
    .ram_sel(r_sel[0]), .ram_wr_n(r_wr_n[0]), .ram_rd_n(r_rd_n[0]),
    .ram_dq_out(r_dq_out[0]), .ram_dq_oe(r_dq_oe[0]), .ram_dq_in(r_dq_in[0]));

  sram_async_ctrl #(.END_MODE(1)) u_dut_e1 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack[1]), .rdata(rdata[1]), .ram_addr(r_addr[1]), .ram_sel_n(r_sel_n[1]),
    .ram_sel(r_sel[1]), .ram_wr_n(r_wr_n[1]), .ram_rd_n(r_rd_n[1]),
    .ram_dq_out(r_dq_out[1]), .ram_dq_oe(r_dq_oe[1]), .ram_dq_in(r_dq_in[1]));

  sram_async_ctrl #(.END_MODE(2)) u_dut_e2 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack[2]), .rdata(rdata[2]), .ram_addr(r_addr[2]), .ram_sel_n(r_sel_n[2]),
    .ram_sel(r_sel[2]), .ram_wr_n(r_wr_n[2]), .ram_rd_n(r_rd_n[2]),
    .ram_dq_out(r_dq_out[2]), .ram_dq_oe(r_dq_oe[2]), .ram_dq_in(r_dq_in[2]));

  for (genvar g = 0; g < 3; g++) begin : g_model
    sram_model #(.MODE(g)) u_model (
      .clk(clk), .rst(rst), .addr(r_addr[g]), .sel_n(r_sel_n[g]), .sel(r_sel[g]),
      .wr_n(r_wr_n[g]), .rd_n(r_rd_n[g]), .dq_out(r_dq_out[g]), .dq_oe(r_dq_oe[g]),
      .dq_in(r_dq_in[g]), .nchk(m_chk[g]), .nfail(m_fail[g]));
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic report();
    int tc;
    int tf;
    tc = n_chk + m_chk[0] + m_chk[1] + m_chk[2];
    tf = n_fail + m_fail[0] + m_fail[1] + m_fail[2];
    $display("%0d/%0d checks passed", tc - tf, tc);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (ack[0] && prev_ack) check(0, "R9 ack longer than one cycle", 1, 0);
      if (ack[0]) begin
        if (sb_q.size() == 0) begin
          check(0, "R8 unexpected ack", 1, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.rd) check(rdata[0] == it.exp, "R2 read data", int'(rdata[0]), int'(it.exp));
          else       check(rdata[0] == it.exp, "R9 rdata held over write", int'(rdata[0]), int'(it.exp));
          check(ack[1] && ack[2] && rdata[1] == rdata[0] && rdata[2] == rdata[0],
                "R4 modes agree", int'({rdata[1], rdata[2]}), int'({rdata[0], rdata[0]}));
          check(r_sel_n[0] && !r_sel[0] && !r_dq_oe[0], "R5 deselected at ack",
                int'({r_sel_n[0], r_sel[0], r_dq_oe[0]}), 3'b100);
        end
      end
      prev_ack = ack[0];
    end
  end

  // driver: one transaction, intrude > 0 places a stray request that many cycles in
  task automatic op(input bit w, input logic [12:0] a, input logic [7:0] d, input int intrude);
    item_t it;
    int n;
    it.rd  = !w;
    it.exp = w ? last_rd : (ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    if (!w) last_rd = it.exp;
    else ref_mem[int'(a)] = d;
    sb_q.push_back(it);
    req = 1'b1; we = w; addr = a; wdata = d;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == intrude) begin
        req = 1'b1; we = 1'b1; wdata = 8'h77;
      end else begin
        req = 1'b0;
      end
      if (ack[0] || n > 200) break;
    end
    check(n == (w ? LAT_WR : LAT_RD) + 1, w ? "R5 write latency" : "R5 read latency",
          n, (w ? LAT_WR : LAT_RD) + 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected < 50000", cycles);
        report();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(r_sel_n[0] && !r_sel[0] && r_wr_n[0] && r_rd_n[0] && !r_dq_oe[0] && !ack[0],
          "R1 pins in reset", int'({r_sel_n[0], r_sel[0], r_wr_n[0], r_rd_n[0], r_dq_oe[0], ack[0]}), 6'b101100);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(r_sel_n[0] && !r_sel[0] && r_wr_n[0] && r_rd_n[0] && !r_dq_oe[0] && !ack[0],
          "R1 pins idle after reset", int'({r_sel_n[0], r_sel[0], r_wr_n[0], r_rd_n[0], r_dq_oe[0], ack[0]}), 6'b101100);
    check(rdata[0] == 8'h00, "R1 rdata after reset", int'(rdata[0]), 0);

    // R2/R3 basic and boundary addresses
    op(1'b1, 13'h0000, 8'h3C, 0);
    op(1'b1, 13'h1FFF, 8'hC3, 0);
    op(1'b0, 13'h0000, 8'h00, 0);
    op(1'b0, 13'h1FFF, 8'h00, 0);
    op(1'b0, 13'h0ABC, 8'h00, 0);  // never written
    // R9 rdata holds across writes
    op(1'b1, 13'h0ABC, 8'hFF, 0);
    op(1'b1, 13'h0ABC, 8'h01, 0);  // overwrite
    op(1'b0, 13'h0ABC, 8'h00, 0);
    // R8 stray request during a read
    op(1'b0, 13'h1FFF, 8'h00, 3);
    op(1'b0, 13'h1FFF, 8'h00, 0);
    // R2/R3 patterned traffic, back to back
    for (int i = 0; i < 24; i++) begin
      op(1'b1, 13'((i * 1237 + 5) % 8192), 8'((i * 29) ^ 8'h5A), 0);
    end
    for (int i = 23; i >= 0; i--) begin
      op(1'b0, 13'((i * 1237 + 5) % 8192), 8'h00, 0);
    end
    op(1'b1, 13'h0000, 8'h00, 0);
    op(1'b0, 13'h0000, 8'h00, 0);
    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R8 outstanding items", sb_q.size(), 0);
    report();
  end

endmodule